// File: doc/BRIEF.md
# Turn-Synchronous Notch Comb Filter

This block sits in the digital path of a transverse beam feedback loop. Its input is a stream of signed pickup samples, at most one per clock. The sample clock is locked to an integer multiple of the ring revolution frequency. One revolution therefore always spans the same number of samples, even while the revolution frequency drifts slowly. The block subtracts from each new sample the sample taken exactly one or two revolutions earlier. This cancels the revolution harmonics and the closed-orbit content, and it keeps the betatron sidebands. The difference goes out at a wider signed width toward the kicker DAC path.

Software sets the revolution length in samples, the one-turn or two-turn delay, and a bypass through a small configuration write port. A write only stages the values. They become active at the start of the next revolution, so a change never splits a turn. After reset, or after the revolution length or delay choice changes, the output stays at zero until the history holds enough valid samples for the selected delay. Memory left over from before therefore never reaches the kicker.

Top module: `turn_comb_filter`

## Requirements
- R1: While reset is applied and after it is released, out_valid is 0 and out_data is 0. The active configuration after reset is a revolution length of KMAX (1600) samples, one-turn delay, bypass off.
- R2: A sample accepted on clock edge N (samp_valid high) produces out_valid high for exactly the cycle that follows edge N+1. In every other cycle out_valid is 0 and out_data is 0. The latency is the same in filter and bypass modes.
- R3: In one-turn mode with bypass off and history filled, out_data equals the accepted sample minus the sample accepted k valid samples earlier. The difference is computed in 11 bits and sign-extended to 12 bits (two's complement).
- R4: In two-turn mode with bypass off and history filled, out_data equals the accepted sample minus the sample accepted 2k valid samples earlier.
- R5: With bypass on, out_data equals the accepted sample sign-extended to 12 bits, whether or not the history is filled.
- R6: With bypass off, out_data is 0 for a valid sample until at least d samples have been accepted since reset or since the last change of k or delay mode. Here d is k (one-turn) or 2k (two-turn). Toggling only the bypass does not restart this count.
- R7: A write (cfg_wr high) only stages k, the delay mode and the bypass. The staged values become active for the first valid sample after the sample that completes the current revolution, that is, the k-th valid sample since the last revolution start.
- R8: A write whose cfg_turn_len is 0 or greater than KMAX is ignored entirely: none of k, the delay mode or the bypass is staged.
- R9: Cycles with samp_valid low neither advance the history nor the revolution position, and they produce no output.
- R10: Extreme inputs are handled at full precision: 511 minus -512 gives 1023 and -512 minus 511 gives -1023 on the 12-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, locked to the revolution frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Input sample strobe |
| samp_in | input | 10 | Signed input sample |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_turn_len | input | 11 | Revolution length k in samples, 1..KMAX |
| cfg_two_turn | input | 1 | 1 selects a two-revolution delay, 0 one revolution |
| cfg_bypass | input | 1 | 1 passes the input through unfiltered |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 12 | Signed filtered output sample |

## Verification
Each result is due after two register stages. A sample accepted on one rising edge appears on the outputs after the next rising edge. The bench drives and samples on falling edges, so it compares each falling edge against the expectation queued two falling edges earlier. The bench checks out_valid and out_data in every cycle, idle ones included. A staged configuration takes effect one sample after the k-th valid sample of the current revolution. The bench's arithmetic model tracks the revolution position, gaps included, and moves to the new settings at exactly that sample. Sweeps over small revolution lengths in both delay modes, with and without gaps, cover fill, wrap and mode-change timing.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    typedef struct packed {
        logic two_turn;
        logic bypass;
    } tcf_mode_t;

    localparam tcf_mode_t TCF_MODE_RESET = '{two_turn: 1'b0, bypass: 1'b0};

endpackage

// File: rtl/tcf_delay_ram.sv
module tcf_delay_ram #(
    parameter int DEPTH = 3200,
    parameter int DW    = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          acc,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    // Read-before-write: in two-turn mode both addresses match and the
    // oldest entry must be returned before it is overwritten.
    always_ff @(posedge clk) begin
        if (acc) begin
            rd_q          <= mem[rd_addr];
            mem[wr_addr]  <= wr_data;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tcf_ctrl.sv
module tcf_ctrl
    import tcf_pkg::*;
#(
    parameter int KMAX = 1600,
    localparam int KW  = $clog2(KMAX + 1),
    localparam int AW  = $clog2(2 * KMAX),
    localparam int FW  = $clog2(2 * KMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_valid,
    input  logic          cfg_wr,
    input  logic [KW-1:0] cfg_turn_len,
    input  logic          cfg_two_turn,
    input  logic          cfg_bypass,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          hist_ok,
    output logic          bypass_now
);

    typedef struct packed {
        logic [KW-1:0] stg_k;
        tcf_mode_t     stg_m;
        logic [KW-1:0] act_k;
        tcf_mode_t     act_m;
        logic [KW-1:0] phase;
        logic [AW-1:0] wp;
        logic [FW-1:0] fill;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [FW-1:0] span;
    logic [FW-1:0] need;
    logic          last_in_turn;
    logic          len_ok;
    logic [AW-1:0] rd_sel;

    always_comb begin
        st_d         = st_q;
        span         = FW'(st_q.act_k) << 1;
        need         = st_q.act_m.two_turn ? span : FW'(st_q.act_k);
        last_in_turn = (st_q.phase == st_q.act_k - KW'(1));
        len_ok       = (cfg_turn_len != '0) && (cfg_turn_len <= KW'(KMAX));

        if (st_q.act_m.two_turn) begin
            rd_sel = st_q.wp;
        end else if (st_q.wp >= AW'(st_q.act_k)) begin
            rd_sel = st_q.wp - AW'(st_q.act_k);
        end else begin
            rd_sel = st_q.wp + AW'(st_q.act_k);
        end

        if (samp_valid) begin
            st_d.wp   = (st_q.wp == AW'(span - FW'(1))) ? '0 : st_q.wp + AW'(1);
            st_d.fill = (st_q.fill == span) ? st_q.fill : st_q.fill + FW'(1);
            if (last_in_turn) begin
                st_d.phase = '0;
                st_d.act_k = st_q.stg_k;
                st_d.act_m = st_q.stg_m;
                if ((st_q.stg_k != st_q.act_k) ||
                    (st_q.stg_m.two_turn != st_q.act_m.two_turn)) begin
                    st_d.fill = '0;
                end
                if (st_q.stg_k != st_q.act_k) begin
                    st_d.wp = '0;
                end
            end else begin
                st_d.phase = st_q.phase + KW'(1);
            end
        end

        if (cfg_wr && len_ok) begin
            st_d.stg_k          = cfg_turn_len;
            st_d.stg_m.two_turn = cfg_two_turn;
            st_d.stg_m.bypass   = cfg_bypass;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stg_k <= KW'(KMAX);
            st_q.stg_m <= TCF_MODE_RESET;
            st_q.act_k <= KW'(KMAX);
            st_q.act_m <= TCF_MODE_RESET;
            st_q.phase <= '0;
            st_q.wp    <= '0;
            st_q.fill  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr    = st_q.wp;
    assign rd_addr    = rd_sel;
    assign hist_ok    = (st_q.fill >= need);
    assign bypass_now = st_q.act_m.bypass;

    AST_PTR_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        FW'(st_q.wp) < (FW'(st_q.act_k) << 1)); // R4
    AST_PHASE_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < st_q.act_k); // R7
    AST_CFG_HELD_MIDTURN: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_valid && last_in_turn) |=> ($stable(st_q.act_k) && $stable(st_q.act_m))); // R7
    AST_STAGED_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg_k != '0) && (st_q.stg_k <= KW'(KMAX))); // R8
    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= (FW'(st_q.act_k) << 1)); // R6
    AST_FILL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && last_in_turn && (st_q.stg_k != st_q.act_k)) |=> (st_q.fill == '0)); // R6
    AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> ($stable(st_q.wp) && $stable(st_q.phase))); // R9

endmodule

// File: rtl/tcf_datapath.sv
module tcf_datapath #(
    parameter int IW = 10,
    parameter int OW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_x,
    input  logic          in_hist_ok,
    input  logic          in_bypass,
    input  logic [IW-1:0] mem_old,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    typedef struct packed {
        logic          s1_valid;
        logic [IW-1:0] s1_x;
        logic          s1_ok;
        logic          s1_byp;
        logic          s2_valid;
        logic [OW-1:0] s2_data;
    } dp_st_t;

    dp_st_t st_d, st_q;

    logic [IW:0]   diff;
    logic [OW-1:0] x_wide;
    logic [OW-1:0] diff_wide;

    always_comb begin
        st_d          = st_q;
        diff          = {st_q.s1_x[IW-1], st_q.s1_x} - {mem_old[IW-1], mem_old};
        x_wide        = {{(OW-IW){st_q.s1_x[IW-1]}}, st_q.s1_x};
        diff_wide     = {{(OW-IW-1){diff[IW]}}, diff};

        st_d.s1_valid = in_valid;
        st_d.s1_x     = in_valid ? in_x : st_q.s1_x;
        st_d.s1_ok    = in_hist_ok;
        st_d.s1_byp   = in_bypass;

        st_d.s2_valid = st_q.s1_valid;
        if (!st_q.s1_valid) begin
            st_d.s2_data = '0;
        end else if (st_q.s1_byp) begin
            st_d.s2_data = x_wide;
        end else if (st_q.s1_ok) begin
            st_d.s2_data = diff_wide;
        end else begin
            st_d.s2_data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2_valid;
    assign out_data  = st_q.s2_data;

    AST_TWO_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0)); // R2
    AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[OW-1:IW] == {(OW-IW){out_data[IW]}})); // R10

endmodule

// File: rtl/turn_comb_filter.sv
module turn_comb_filter #(
    parameter int KMAX  = 1600,
    parameter int IW    = 10,
    parameter int OW    = 12,
    localparam int KW   = $clog2(KMAX + 1),
    localparam int DEPTH = 2 * KMAX,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_valid,
    input  logic [IW-1:0] samp_in,
    input  logic          cfg_wr,
    input  logic [KW-1:0] cfg_turn_len,
    input  logic          cfg_two_turn,
    input  logic          cfg_bypass,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          hist_ok;
    logic          bypass_now;
    logic [IW-1:0] mem_old;

    tcf_ctrl #(.KMAX(KMAX)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_valid   (samp_valid),
        .cfg_wr       (cfg_wr),
        .cfg_turn_len (cfg_turn_len),
        .cfg_two_turn (cfg_two_turn),
        .cfg_bypass   (cfg_bypass),
        .wr_addr      (wr_addr),
        .rd_addr      (rd_addr),
        .hist_ok      (hist_ok),
        .bypass_now   (bypass_now)
    );

    tcf_delay_ram #(.DEPTH(DEPTH), .DW(IW)) u_ram (
        .clk     (clk),
        .acc     (samp_valid),
        .wr_addr (wr_addr),
        .wr_data (samp_in),
        .rd_addr (rd_addr),
        .rd_data (mem_old)
    );

    tcf_datapath #(.IW(IW), .OW(OW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (samp_valid),
        .in_x       (samp_in),
        .in_hist_ok (hist_ok),
        .in_bypass  (bypass_now),
        .mem_old    (mem_old),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_data == '0))); // R1

endmodule

// File: tb/turn_comb_filter_tb.sv
module turn_comb_filter_tb;

    localparam int KMAX = 1600;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        samp_valid;
    logic [9:0]  samp_in;
    logic        cfg_wr;
    logic [10:0] cfg_turn_len;
    logic        cfg_two_turn;
    logic        cfg_bypass;
    logic        out_valid;
    logic [11:0] out_data;

    always #5 clk = ~clk;

    turn_comb_filter #(.KMAX(KMAX)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_valid   (samp_valid),
        .samp_in      (samp_in),
        .cfg_wr       (cfg_wr),
        .cfg_turn_len (cfg_turn_len),
        .cfg_two_turn (cfg_two_turn),
        .cfg_bypass   (cfg_bypass),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // arithmetic reference state
    int m_stgk = KMAX, m_actk = KMAX, m_phase = 0;
    bit m_stg2 = 0, m_stgb = 0, m_act2 = 0, m_actb = 0;
    int hist[$];

    // expectation pipeline, two falling edges deep
    bit    pv0 = 0, pv1 = 0;
    int    pd0 = 0, pd1 = 0;
    string pr0 = "R2", pr1 = "R2";
    string cur_req = "R1";

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_sample(int x);
        int d;
        int y;
        d = m_act2 ? 2 * m_actk : m_actk;
        if (m_actb)                 y = x;
        else if (hist.size() >= d)  y = x - hist[hist.size() - d];
        else                        y = 0;
        hist.push_back(x);
        if (hist.size() > 4000) void'(hist.pop_front());
        if (m_phase == m_actk - 1) begin
            m_phase = 0;
            if (m_stgk != m_actk || m_stg2 != m_act2) hist.delete();
            m_actk = m_stgk;
            m_act2 = m_stg2;
            m_actb = m_stgb;
        end else begin
            m_phase++;
        end
        return y;
    endfunction

    // called at a falling edge: check outputs, drive one cycle of inputs
    task automatic step(bit v, int x, bit wr, int wk, bit w2, bit wb);
        int a;
        int y;
        a = $signed(out_data);
        check("R2", int'(out_valid), int'(pv1), "out_valid");
        if (pv1) check(pr1, a, pd1, "out_data");
        else     check("R2", a, 0, "idle out_data");
        pv1 = pv0; pd1 = pd0; pr1 = pr0;
        samp_valid   = v;
        samp_in      = 10'(x);
        cfg_wr       = wr;
        cfg_turn_len = 11'(wk);
        cfg_two_turn = w2;
        cfg_bypass   = wb;
        y = 0;
        if (v) y = model_sample(x);
        if (wr && wk >= 1 && wk <= KMAX) begin
            m_stgk = wk; m_stg2 = w2; m_stgb = wb;
        end
        pv0 = v; pd0 = y; pr0 = cur_req;
        @(negedge clk);
    endtask

    function automatic int rnd_samp();
        return int'($urandom_range(0, 1023)) - 512;
    endfunction

    task automatic feed(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            bit v;
            v = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
            step(v, rnd_samp(), 0, 0, 0, 0);
        end
    endtask

    task automatic write_cfg(int k, bit two, bit byp);
        step(0, 0, 1, k, two, byp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; samp_valid = 0; samp_in = '0; cfg_wr = 0;
        cfg_turn_len = '0; cfg_two_turn = 0; cfg_bypass = 0;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0, "out_valid in reset");
        check("R1", int'(out_data), 0, "out_data in reset");
        rst_n = 1;
        @(negedge clk);
        check("R1", int'(out_valid), 0, "out_valid after reset");

        // R1/R6: default k=1600 turn stays zero; stage k=8 for next turn (R7)
        cur_req = "R6";
        write_cfg(8, 0, 0);
        feed(KMAX, 0);
        // R3: one-turn filtering with k=8, contiguous samples
        cur_req = "R3";
        feed(80, 0);
        // R9: gaps do not advance history
        cur_req = "R9";
        feed(120, 1);
        // R4 and R7: staged two-turn switch, effective at wrap
        cur_req = "R4";
        write_cfg(8, 1, 0);
        feed(100, 0);
        // R5: bypass passes input, then back without refill
        cur_req = "R5";
        write_cfg(8, 1, 1);
        feed(40, 1);
        write_cfg(8, 1, 0);
        feed(40, 0);
        // R8: illegal lengths ignored, mode bits not staged
        cur_req = "R8";
        write_cfg(0, 0, 1);
        feed(40, 0);
        write_cfg(KMAX + 1, 0, 1);
        feed(40, 0);
        // R10: extremes at k=1 in both modes
        cur_req = "R10";
        write_cfg(1, 0, 0);
        for (int i = 0; i < 40; i++) step(1, (i % 2 == 0) ? 511 : -512, 0, 0, 0, 0);
        write_cfg(1, 1, 0);
        for (int i = 0; i < 40; i++) step(1, ((i / 2) % 2 == 0) ? 511 : -512, 0, 0, 0, 0);
        // R7 sweep: small k, both modes, with and without gaps
        for (int k = 1; k <= 12; k++) begin
            for (int m = 0; m < 2; m++) begin
                cur_req = (m == 0) ? "R3" : "R4";
                write_cfg(k, m[0], 0);
                feed(6 * k + 30, k[0]);
            end
        end
        cur_req = "R7";
        write_cfg(5, 0, 0);
        feed(3, 0);
        write_cfg(3, 1, 0);
        feed(40, 1);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule